// File: doc/BRIEF.md
# Flash Command Key Guard

This block stands in front of the command port of an on-chip flash controller and keeps destructive operations (program, erase and compaction) shut off until software has proved it knows the protection keys. Four 32-bit reference keys are held in a fixed place in flash, namely the final four words of the first 64K-byte sector. They reach the block as one flat input vector. Software unlocks the flash by writing its own four keys, one after another, to a single key register. Each write is compared with the reference key whose turn it is. The block unlocks only when all four writes match, in order.

A mismatching write sends the sequence back to the first key. A write to the lock register, or any reset, closes the guard again and clears the sequence. Read requests pass through whatever the key state is. A blocked command request is answered with a reject pulse in the same cycle, and it also sets a violation flag that stays set until reset.

Top module: `fkey_guard`

## Requirements
- R1: After reset `unlocked` is 0, `key_index` is 0 and `violation` is 0.
- R2: While locked, a write to the key register (address 0) whose data equals the reference key at position `key_index` raises `key_index` by one in the following cycle. Reference key i occupies bits [32*i+31:32*i] of `ref_keys`.
- R3: While locked, a matching write at position 3 sets `unlocked` to 1 and returns `key_index` to 0 in the following cycle.
- R4: While locked, a key write whose data does not equal the reference key at `key_index` returns `key_index` to 0 and leaves the block locked. Keys written out of order therefore never unlock it.
- R5: A write to the lock register (address 1), whatever its data, leaves `unlocked` at 0 and `key_index` at 0 in the following cycle.
- R6: Command codes 1 (program), 2 (erase) and 3 (compaction) are granted when unlocked. When locked, they are refused: `cmd_grant` is 0 and `cmd_reject` is 1 in the same cycle as the request.
- R7: Command code 0 (read) is always granted and never rejected, and it never sets `violation`.
- R8: `violation` becomes 1 in the cycle after any reject and stays 1 until reset, including after a later unlock.
- R9: Key writes while unlocked, and writes to any address other than 0 or 1, change neither `unlocked` nor `key_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register address: 0 key, 1 lock |
| reg_wr_data | input | 32 | Register write data |
| ref_keys | input | 128 | Four reference keys, key 0 in the low word |
| cmd_req | input | 1 | Flash command request |
| cmd_type | input | 2 | 0 read, 1 program, 2 erase, 3 compaction |
| cmd_grant | output | 1 | Request forwarded to the controller |
| cmd_reject | output | 1 | Request refused this cycle |
| unlocked | output | 1 | All four keys matched |
| violation | output | 1 | Sticky record of a refused request |
| key_index | output | 2 | Position of the next expected key |

## Verification
The key sequence is driven with every prefix of correct keys, from none up to three. Each prefix is followed by a corrupted key and, separately, by the next-but-one key. This tells a reset-to-zero on a miss apart from a stalled or skipped index, and it shows that the order of the keys matters. Every command code is presented in both the locked and the unlocked state. This separates the read bypass from the gated codes and shows when the sticky flag is set. Lock-register writes are issued both mid-sequence and after a full unlock. Writes to an unused address, and key writes made while unlocked, are issued with otherwise valid data, so that a decoding slip would show up as a change in state.

// File: rtl/fkey_pkg.sv
package fkey_pkg;

  typedef enum logic [1:0] {
    CMD_READ    = 2'd0,
    CMD_PROGRAM = 2'd1,
    CMD_ERASE   = 2'd2,
    CMD_COMPACT = 2'd3
  } cmd_kind_e;

  // A command kind that can alter the array contents
  function automatic logic is_destructive(input logic [1:0] kind);
    return kind != CMD_READ;
  endfunction

endpackage

// File: rtl/fkey_cmp.sv
module fkey_cmp #(
  parameter int NKEYS = 4,
  parameter int KEY_W = 32
) (
  input  logic [KEY_W-1:0]       wr_data,
  input  logic [NKEYS*KEY_W-1:0] ref_keys,
  output logic [NKEYS-1:0]       hit_vec
);

  function automatic logic [KEY_W-1:0] key_at(
    input logic [NKEYS*KEY_W-1:0] flat,
    input int                     pos
  );
    return flat[pos*KEY_W +: KEY_W];
  endfunction

  for (genvar g = 0; g < NKEYS; g++) begin : g_cmp
    assign hit_vec[g] = (wr_data == key_at(ref_keys, g));
  end

endmodule

// File: rtl/fkey_seq.sv
module fkey_seq #(
  parameter int NKEYS = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic             lock_wr,
  input  logic [NKEYS-1:0] hit_vec,
  output logic [IDX_W-1:0] idx,
  output logic             unlocked,
  output logic             key_hit,
  output logic             key_miss,
  output logic             last_hit
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NKEYS - 1);

  function automatic logic [IDX_W-1:0] step_idx(
    input logic [IDX_W-1:0] cur,
    input logic             hit,
    input logic             last
  );
    if (!hit || last) return '0;
    return cur + 1'b1;
  endfunction

  logic sel_hit;

  always_comb begin
    sel_hit  = hit_vec[idx];
    key_hit  = key_wr && !unlocked && sel_hit;
    key_miss = key_wr && !unlocked && !sel_hit;
    last_hit = key_hit && (idx == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      unlocked <= 1'b0;
    end else if (lock_wr) begin
      idx      <= '0;
      unlocked <= 1'b0;
    end else if (key_hit || key_miss) begin
      idx <= step_idx(idx, key_hit, last_hit);
      if (last_hit) unlocked <= 1'b1;
    end
  end

endmodule

// File: rtl/fkey_gate.sv
module fkey_gate
  import fkey_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       cmd_req,
  input  logic [1:0] cmd_type,
  output logic       cmd_grant,
  output logic       cmd_reject,
  output logic       violation
);

  logic blocked;

  always_comb begin
    blocked    = is_destructive(cmd_type) && !unlocked;
    cmd_grant  = cmd_req && !blocked;
    cmd_reject = cmd_req && blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          violation <= 1'b0;
    else if (cmd_reject) violation <= 1'b1;
  end

endmodule

// File: rtl/fkey_guard.sv
module fkey_guard #(
  parameter int          NKEYS     = 4,
  parameter int          KEY_W     = 32,
  parameter int          ADDR_W    = 4,
  parameter int unsigned KEY_ADDR  = 0,
  parameter int unsigned LOCK_ADDR = 1,
  localparam int         IDX_W     = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr_en,
  input  logic [ADDR_W-1:0]      reg_wr_addr,
  input  logic [KEY_W-1:0]       reg_wr_data,
  input  logic [NKEYS*KEY_W-1:0] ref_keys,
  input  logic                   cmd_req,
  input  logic [1:0]             cmd_type,
  output logic                   cmd_grant,
  output logic                   cmd_reject,
  output logic                   unlocked,
  output logic                   violation,
  output logic [IDX_W-1:0]       key_index
);

  logic             key_wr;
  logic             lock_wr;
  logic [NKEYS-1:0] hit_vec;
  logic             key_hit;
  logic             key_miss;
  logic             last_hit;

  assign key_wr  = reg_wr_en && (reg_wr_addr == ADDR_W'(KEY_ADDR));
  assign lock_wr = reg_wr_en && (reg_wr_addr == ADDR_W'(LOCK_ADDR));

  fkey_cmp #(.NKEYS(NKEYS), .KEY_W(KEY_W)) u_cmp (
    .wr_data  (reg_wr_data),
    .ref_keys (ref_keys),
    .hit_vec  (hit_vec)
  );

  fkey_seq #(.NKEYS(NKEYS), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .lock_wr  (lock_wr),
    .hit_vec  (hit_vec),
    .idx      (key_index),
    .unlocked (unlocked),
    .key_hit  (key_hit),
    .key_miss (key_miss),
    .last_hit (last_hit)
  );

  fkey_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .unlocked   (unlocked),
    .cmd_req    (cmd_req),
    .cmd_type   (cmd_type),
    .cmd_grant  (cmd_grant),
    .cmd_reject (cmd_reject),
    .violation  (violation)
  );

endmodule

// File: rtl/fkey_guard_chk.sv
module fkey_guard_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_req,
  input logic [1:0]       cmd_type,
  input logic             cmd_grant,
  input logic             cmd_reject,
  input logic             unlocked,
  input logic             violation,
  input logic [IDX_W-1:0] key_index,
  input logic             key_wr,
  input logic             lock_wr,
  input logic             key_hit,
  input logic             key_miss,
  input logic             last_hit
);

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_hit && !last_hit) |=> key_index == IDX_W'($past(key_index) + 1'b1));

  // R3
  unlock_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |=> (unlocked && key_index == '0));

  // R3
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(last_hit));

  // R4
  miss_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_miss |=> (key_index == '0 && !unlocked));

  // R5
  lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |=> (!unlocked && key_index == '0));

  // R6
  reject_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> (!unlocked && cmd_type != 2'd0 && !cmd_grant));

  // R6
  grant_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && unlocked) |-> cmd_grant);

  // R7
  read_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_type == 2'd0) |-> (cmd_grant && !cmd_reject));

  // R8
  violation_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |=> violation);

  // R8
  violation_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);

  // R9
  open_key_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && unlocked && !lock_wr) |=> unlocked);

endmodule

bind fkey_guard fkey_guard_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_req    (cmd_req),
  .cmd_type   (cmd_type),
  .cmd_grant  (cmd_grant),
  .cmd_reject (cmd_reject),
  .unlocked   (unlocked),
  .violation  (violation),
  .key_index  (key_index),
  .key_wr     (key_wr),
  .lock_wr    (lock_wr),
  .key_hit    (key_hit),
  .key_miss   (key_miss),
  .last_hit   (last_hit)
);

// File: tb/tb_fkey_guard.sv
module tb_fkey_guard;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [3:0]   reg_wr_addr = '0;
  logic [31:0]  reg_wr_data = '0;
  logic [127:0] ref_keys;
  logic         cmd_req = 1'b0;
  logic [1:0]   cmd_type = '0;
  logic         cmd_grant, cmd_reject, unlocked, violation;
  logic [1:0]   key_index;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fkey_guard dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .ref_keys(ref_keys), .cmd_req(cmd_req),
    .cmd_type(cmd_type), .cmd_grant(cmd_grant), .cmd_reject(cmd_reject),
    .unlocked(unlocked), .violation(violation), .key_index(key_index)
  );

  function automatic logic [31:0] ref_key(input int i);
    return 32'h1357_9BDF + 32'h1111_1111 * i;
  endfunction

  initial for (int i = 0; i < 4; i++) ref_keys[i*32 +: 32] = ref_key(i);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one register write; returns at the negedge after the capturing edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic unlock_all();
    for (int i = 0; i < 4; i++) wr(4'd0, ref_key(i));
  endtask

  // present a command; checks grant/reject in the same cycle
  task automatic cmd(input logic [1:0] t, input logic exp_grant, input string req);
    @(negedge clk);
    cmd_req = 1'b1; cmd_type = t;
    #1;
    check(req, {31'd0, cmd_grant}, {31'd0, exp_grant});
    check(req, {31'd0, cmd_reject}, {31'd0, !exp_grant});
    @(negedge clk);
    cmd_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", {31'd0, unlocked}, 0);
    check("R1", {30'd0, key_index}, 0);
    check("R1", {31'd0, violation}, 0);

    // R7 read while locked
    cmd(2'd0, 1'b1, "R7");
    check("R7", {31'd0, violation}, 0);

    // R6 destructive kinds while locked, R8 sticky set
    for (int t = 1; t < 4; t++) begin
      cmd(2'(t), 1'b0, "R6");
      check("R8", {31'd0, violation}, 1);
    end

    // R2/R4 sweep over every prefix length with a corrupted key
    do_reset();
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < k; i++) begin
        wr(4'd0, ref_key(i));
        check("R2", {30'd0, key_index}, 32'(i + 1));
      end
      wr(4'd0, ref_key(k) ^ 32'h0000_0100);
      check("R4", {30'd0, key_index}, 0);
      check("R4", {31'd0, unlocked}, 0);
    end
    // R4 out-of-order key: prefix k then key k+1
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < k; i++) wr(4'd0, ref_key(i));
      wr(4'd0, ref_key(k + 1));
      check("R4", {30'd0, key_index}, 0);
      check("R4", {31'd0, unlocked}, 0);
    end

    // R9 unused address while locked
    wr(4'd2, ref_key(0));
    check("R9", {30'd0, key_index}, 0);

    // R3 full unlock
    unlock_all();
    check("R3", {31'd0, unlocked}, 1);
    check("R3", {30'd0, key_index}, 0);

    // R6 granted when open, R7 read too; R8 stays clear
    for (int t = 0; t < 4; t++) cmd(2'(t), 1'b1, "R6");
    check("R8", {31'd0, violation}, 0);

    // R9 key writes while open, and an unused address
    wr(4'd0, 32'hDEAD_BEEF);
    check("R9", {31'd0, unlocked}, 1);
    wr(4'd0, ref_key(0));
    check("R9", {30'd0, key_index}, 0);
    wr(4'd7, 32'h0);
    check("R9", {31'd0, unlocked}, 1);

    // R5 lock write after unlock, arbitrary data
    wr(4'd1, 32'h1234_5678);
    check("R5", {31'd0, unlocked}, 0);
    cmd(2'd2, 1'b0, "R5");
    // R5 lock write mid-sequence
    wr(4'd0, ref_key(0));
    wr(4'd0, ref_key(1));
    check("R2", {30'd0, key_index}, 2);
    wr(4'd1, ref_key(2));
    check("R5", {30'd0, key_index}, 0);
    check("R5", {31'd0, unlocked}, 0);

    // R8 sticky across unlock
    unlock_all();
    check("R3", {31'd0, unlocked}, 1);
    repeat (3) @(negedge clk);
    check("R8", {31'd0, violation}, 1);

    do_reset();
    check("R1", {31'd0, violation}, 0);
    check("R1", {31'd0, unlocked}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule